// File: doc/BRIEF.md
# Bidirectional Rotating Shift Register

This block is a serial storage chain of `DEPTH` one-bit stages (32 by default, numbered 1 to `DEPTH`). On each rising clock edge it moves every bit one position toward the high end or the low end. The `dir_left` input picks the direction. The `hold` input freezes the chain. The `ext_feed` input selects the bit that enters the vacated end stage. With `ext_feed` high, that bit comes from the serial input for that direction. With `ext_feed` low, the bit that drops off the far end wraps around, so the contents rotate.

Two taps show the end stages: `tap_first` shows stage 1 and `tap_last` shows stage `DEPTH`. Each tap is registered again on the falling clock edge, so it updates half a cycle after the rising edge that loaded its stage. This half-cycle skew lets `tap_last` of one instance drive `ser_in_r` of the next instance on the same clock. The chained instances then form a longer delay line or a deeper stack.

The mode inputs are sampled on the rising edge and must stay unchanged while the clock is high. An active-low asynchronous reset clears the chain and both taps.

Top module: `bidir_loop_shifter`

## Requirements
- R1: While `rst_n` is low, every stage and both taps are 0. This holds immediately, without waiting for a clock edge.
- R2: With `dir_left`=0, `ext_feed`=1 and `hold`=0, a rising edge moves stage k into stage k+1 and loads `ser_in_r` into stage 1.
- R3: With `dir_left`=1, `ext_feed`=1 and `hold`=0, a rising edge moves stage k+1 into stage k and loads `ser_in_l` into stage `DEPTH`.
- R4: With `hold`=1, a rising edge leaves every stage unchanged, whatever the values of the serial inputs and the other mode inputs.
- R5: With `dir_left`=0, `ext_feed`=0 and `hold`=0, a rising edge rotates the chain toward the high end: stage `DEPTH` moves into stage 1 and `ser_in_r` is ignored.
- R6: With `dir_left`=1, `ext_feed`=0 and `hold`=0, a rising edge rotates the chain toward the low end: stage 1 moves into stage `DEPTH` and `ser_in_l` is ignored.
- R7: On each falling clock edge, `tap_first` takes the value of stage 1 and `tap_last` takes the value of stage `DEPTH`.
- R8: A rising edge does not change either tap. Between a rising edge and the next falling edge, both taps still show the stage values from before that rising edge.
- R9: `dir_left`, `ext_feed` and `hold` may change only while the clock is low. A change made in the low phase applies at the very next rising edge. A change while the clock is high is flagged.
- R10: When `tap_last` of one instance drives `ser_in_r` of a second instance on the same clock, both in mode R2, a bit applied to the first instance appears on `tap_last` of the second instance at the falling edge that follows 2·`DEPTH`−1 further rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Stages load on the rising edge; taps load on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_left | input | 1 | 0: move toward stage `DEPTH`; 1: move toward stage 1 |
| ext_feed | input | 1 | 1: the entering bit comes from a serial input; 0: rotate |
| hold | input | 1 | 1: no stage changes on the rising edge |
| ser_in_r | input | 1 | Serial bit loaded into stage 1 in mode R2 |
| ser_in_l | input | 1 | Serial bit loaded into stage `DEPTH` in mode R3 |
| tap_first | output | 1 | Stage 1, registered on the falling edge |
| tap_last | output | 1 | Stage `DEPTH`, registered on the falling edge |

## Verification
The bench probes the taps in the high phase, just after each rising edge. A design whose taps follow the stages combinationally, or load on the rising edge, breaks the half-cycle skew there, and a cascade built from it would skip a stage. The bench rotates in both directions after filling the chain with an irregular pattern. A wrap that uses the wrong end stage, or a rotate that still takes the serial bit, then corrupts the bits that come back around. Hold cycles toggle the serial inputs, and the mode changes every cycle in a pseudo-random stretch, so a design that latches the mode late or lets a serial input leak in while held will miscompare. The two-instance chain must show exactly a 2·`DEPTH`−1 edge delay, and an off-by-one in the tap timing shows up as a shifted stream.

// File: rtl/bls_pkg.sv
package bls_pkg;
   typedef enum logic [1:0] {
      MV_HOLD  = 2'd0,
      MV_RIGHT = 2'd1,
      MV_LEFT  = 2'd2
   } move_e;
endpackage

// File: rtl/bls_mode_dec.sv
module bls_mode_dec
   import bls_pkg::*;
(
   input  logic  dir_left,
   input  logic  ext_feed,
   input  logic  hold,
   input  logic  ser_in_r,
   input  logic  ser_in_l,
   input  logic  stage_first,
   input  logic  stage_last,
   output move_e move,
   output logic  entry_bit
);
   always_comb begin
      if (hold)
         move = MV_HOLD;
      else if (dir_left)
         move = MV_LEFT;
      else
         move = MV_RIGHT;
   end

   // Bit entering the vacated end: the serial input, or the bit wrapping off the far end.
   always_comb begin
      if (dir_left)
         entry_bit = ext_feed ? ser_in_l : stage_first;
      else
         entry_bit = ext_feed ? ser_in_r : stage_last;
   end
endmodule

// File: rtl/bls_stage_chain.sv
module bls_stage_chain
   import bls_pkg::*;
#(
   parameter int unsigned DEPTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  move_e            move,
   input  logic             entry_bit,
   output logic [DEPTH-1:0] stage_q
);
   localparam int unsigned LAST = DEPTH - 1;

   logic [DEPTH-1:0] stage_d;

   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      logic from_low;
      logic from_high;
      if (i == 0) begin : g_low_end
         assign from_low = entry_bit;
      end else begin : g_low_mid
         assign from_low = stage_q[i-1];
      end
      if (i == LAST) begin : g_high_end
         assign from_high = entry_bit;
      end else begin : g_high_mid
         assign from_high = stage_q[i+1];
      end
      always_comb begin
         unique case (move)
            MV_RIGHT: stage_d[i] = from_low;
            MV_LEFT:  stage_d[i] = from_high;
            default:  stage_d[i] = stage_q[i];
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stage_q <= '0;
      else
         stage_q <= stage_d;
   end

   p_hold_freezes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (move == MV_HOLD) |=> $stable(stage_q))
      else $error("hold did not freeze the chain");
endmodule

// File: rtl/bls_edge_taps.sv
module bls_edge_taps (
   input  logic clk,
   input  logic rst_n,
   input  logic first_d,
   input  logic last_d,
   output logic tap_first,
   output logic tap_last
);
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tap_first <= 1'b0;
         tap_last  <= 1'b0;
      end else begin
         tap_first <= first_d;
         tap_last  <= last_d;
      end
   end
endmodule

// File: rtl/bidir_loop_shifter.sv
module bidir_loop_shifter
   import bls_pkg::*;
#(
   parameter int unsigned DEPTH = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dir_left,
   input  logic ext_feed,
   input  logic hold,
   input  logic ser_in_r,
   input  logic ser_in_l,
   output logic tap_first,
   output logic tap_last
);
   localparam int unsigned LAST = DEPTH - 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("bidir_loop_shifter: DEPTH must be at least 2");
   end

   move_e            move;
   logic             entry_bit;
   logic [DEPTH-1:0] stage_q;

   bls_mode_dec i_dec (
      .dir_left    (dir_left),
      .ext_feed    (ext_feed),
      .hold        (hold),
      .ser_in_r    (ser_in_r),
      .ser_in_l    (ser_in_l),
      .stage_first (stage_q[0]),
      .stage_last  (stage_q[LAST]),
      .move        (move),
      .entry_bit   (entry_bit)
   );

   bls_stage_chain #(.DEPTH(DEPTH)) i_chain (
      .clk       (clk),
      .rst_n     (rst_n),
      .move      (move),
      .entry_bit (entry_bit),
      .stage_q   (stage_q)
   );

   bls_edge_taps i_taps (
      .clk       (clk),
      .rst_n     (rst_n),
      .first_d   (stage_q[0]),
      .last_d    (stage_q[LAST]),
      .tap_first (tap_first),
      .tap_last  (tap_last)
   );

   // Mode snapshot at the rising edge, compared again at the falling edge.
   logic [2:0] ctrl_snap;
   logic       rose_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_snap <= '0;
         rose_seen <= 1'b0;
      end else begin
         ctrl_snap <= {dir_left, ext_feed, hold};
         rose_seen <= 1'b1;
      end
   end

   p_ctrl_stable_r9: assert property (@(negedge clk) disable iff (!rst_n)
      rose_seen |-> ({dir_left, ext_feed, hold} == ctrl_snap))
      else $error("mode input changed while clock high");

   p_feed_right_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_left && ext_feed && !hold) |=> (stage_q[0] == $past(ser_in_r)))
      else $error("right feed bit not loaded into stage 1");

   p_feed_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_left && ext_feed && !hold) |=> (stage_q[LAST] == $past(ser_in_l)))
      else $error("left feed bit not loaded into last stage");

   p_rot_right_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_left && !ext_feed && !hold) |=> (stage_q[0] == $past(stage_q[LAST])))
      else $error("right rotate did not wrap last stage");

   p_rot_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_left && !ext_feed && !hold) |=> (stage_q[LAST] == $past(stage_q[0])))
      else $error("left rotate did not wrap first stage");

   p_tap_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tap_first == stage_q[0]) && (tap_last == stage_q[LAST]))
      else $error("taps do not match end stages at rising edge");
endmodule

// File: tb/test_bidir_loop_shifter.sv
module test_bidir_loop_shifter;
   localparam int unsigned DEPTH  = 32;
   localparam time         PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dir_left = 1'b0, ext_feed = 1'b1, hold = 1'b0;
   logic ser_in_r = 1'b0, ser_in_l = 1'b0;
   logic tap_first, tap_last;

   logic c_hold = 1'b1, c_in = 1'b0;
   logic c_mid, c0_first, c1_first, c1_last;

   int vectors = 0;
   int fails   = 0;
   logic model[$];

   always #(PERIOD/2) clk = ~clk;

   bidir_loop_shifter #(.DEPTH(DEPTH)) i_bidir_loop_shifter (
      .clk(clk), .rst_n(rst_n), .dir_left(dir_left), .ext_feed(ext_feed),
      .hold(hold), .ser_in_r(ser_in_r), .ser_in_l(ser_in_l),
      .tap_first(tap_first), .tap_last(tap_last));

   bidir_loop_shifter #(.DEPTH(DEPTH)) i_bidir_loop_shifter_c0 (
      .clk(clk), .rst_n(rst_n), .dir_left(1'b0), .ext_feed(1'b1),
      .hold(c_hold), .ser_in_r(c_in), .ser_in_l(1'b0),
      .tap_first(c0_first), .tap_last(c_mid));

   bidir_loop_shifter #(.DEPTH(DEPTH)) i_bidir_loop_shifter_c1 (
      .clk(clk), .rst_n(rst_n), .dir_left(1'b0), .ext_feed(1'b1),
      .hold(c_hold), .ser_in_r(c_mid), .ser_in_l(1'b0),
      .tap_first(c1_first), .tap_last(c1_last));

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   task automatic check(input logic got, input logic exp, input string tag);
      vectors++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic model_clear();
      model.delete();
      for (int i = 0; i < DEPTH; i++) model.push_back(1'b0);
   endtask

   // Called in the low phase; applies one rising edge and checks both phases.
   task automatic step(input logic d, input logic f, input logic h,
                       input logic ri, input logic li, input string tag);
      logic old_first, old_last, t;
      dir_left = d; ext_feed = f; hold = h; ser_in_r = ri; ser_in_l = li;
      old_first = model[0];
      old_last  = model[DEPTH-1];
      @(posedge clk); #1;
      if (!h) begin
         if (!d) begin
            t = f ? ri : model[DEPTH-1];
            void'(model.pop_back());
            model.push_front(t);
         end else begin
            t = f ? li : model[0];
            void'(model.pop_front());
            model.push_back(t);
         end
      end
      check(tap_first, old_first, "R8 tap_first held through rising edge");
      check(tap_last,  old_last,  "R8 tap_last held through rising edge");
      @(negedge clk); #1;
      check(tap_first, model[0],       {tag, " tap_first (R7)"});
      check(tap_last,  model[DEPTH-1], {tag, " tap_last (R7)"});
   endtask

   initial begin
      #(PERIOD * 200000);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      int lfsr;
      logic hist[$];
      model_clear();
      repeat (3) @(negedge clk);
      #1;
      check(tap_first, 1'b0, "R1 reset tap_first");
      check(tap_last,  1'b0, "R1 reset tap_last");
      rst_n = 1'b1;

      // R2: right feed, irregular pattern; reset zeros emerge on tap_last first (R1).
      for (int k = 0; k < 40; k++)
         step(1'b0, 1'b1, 1'b0, logic'(((k * 7 + 3) % 5) < 2), 1'b1, "R2 right feed");
      // R3: left feed.
      for (int k = 0; k < 40; k++)
         step(1'b1, 1'b1, 1'b0, 1'b1, logic'(k[0] ^ k[2]), "R3 left feed");
      // R4: hold while serial inputs and direction toggle.
      for (int k = 0; k < 20; k++)
         step(logic'(k[1]), logic'(k[2]), 1'b1, logic'(k[0]), logic'(~k[0]), "R4 hold");
      // R5: rotate right, serial input must be ignored.
      for (int k = 0; k < 40; k++)
         step(1'b0, 1'b0, 1'b0, logic'(k[0]), 1'b0, "R5 rotate right");
      // R6: rotate left, serial input must be ignored.
      for (int k = 0; k < 40; k++)
         step(1'b1, 1'b0, 1'b0, 1'b0, logic'(~k[1]), "R6 rotate left");
      // R9: mode changes every low phase and applies at the next edge.
      lfsr = 32'h1ACE;
      for (int k = 0; k < 120; k++) begin
         lfsr = (lfsr << 1) ^ ((lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]) ? 1 : 0);
         lfsr = lfsr & 32'hFFFF;
         step(logic'(lfsr[0]), logic'(lfsr[1]), logic'(lfsr[2] & lfsr[3]),
              logic'(lfsr[4]), logic'(lfsr[5]), "R9 mixed modes");
      end

      // R1: asynchronous reset in mid-run.
      rst_n = 1'b0;
      #1;
      check(tap_first, 1'b0, "R1 async reset tap_first");
      check(tap_last,  1'b0, "R1 async reset tap_last");
      model_clear();
      @(negedge clk); #1;
      rst_n = 1'b1;
      for (int k = 0; k < DEPTH; k++)
         step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R1 cleared stages shift out");

      // R10: two-instance delay line of 2*DEPTH-1 edges.
      hold = 1'b1;
      c_hold = 1'b0;
      for (int k = 0; k < 3 * DEPTH + 8; k++) begin
         logic exp;
         c_in = logic'(((k * 5 + 1) % 7) < 3);
         hist.push_back(c_in);
         @(posedge clk);
         @(negedge clk); #1;
         if (hist.size() == 2 * DEPTH) exp = hist.pop_front();
         else exp = 1'b0;
         check(c1_last, exp, "R10 cascaded delay line");
      end

      summary();
      $finish;
   end
endmodule